// File: doc/BRIEF.md
# DMA Event Status and Interrupt Register

This block collects single-cycle event pulses from the receive and transmit paths of a multi-channel packet DMA engine and holds each kind of event in a sticky status bit. Software reads the status register to learn which events happened since its last read. That read clears the bits. The events covered are:

- reads of the receive small-buffer free queue
- receive free-queue reads that found the queue empty
- receive done-queue writes and writes that found the queue full
- transmit pending-queue reads
- transmit done-queue writes and writes that found the queue full
- transmit FIFO underflow on any channel

The two done-queue write events can be coalesced. A per-direction threshold code sets the number of writes needed to raise the status bit, from every write up to one in 128 writes. An interrupt mask register selects which status bits request an interrupt. The request always drives the host interrupt line. It drives the local-bus interrupt line only while the local bus is in configuration mode.

The register port is a simple synchronous port with a 2-bit address. Addresses and field positions are given in the requirements.

Top module: `dma_evt_stat`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears all status bits, the mask, both threshold codes, both write counters, `rdata`, `irq_host` and `irq_local` to zero.
- R2: Each event pulse sets its own status bit at the next edge, and the bit then holds until it is cleared. The positions are: 8 = receive free-queue read (single or burst, one pulse each), 9 = receive free-queue read while empty, 10 = receive done-queue write (after coalescing), 11 = receive done-queue write while full, 12 = transmit underflow, 13 = transmit pending-queue read, 14 = transmit done-queue write (after coalescing), 15 = transmit done-queue write while full.
- R3: A read (`rd_en` high) loads `rdata` at the next edge with the value the selected register held before that edge. `rdata` keeps that value until the next read. A read of address 0 (status) clears every status bit. Status bits 7 to 0 always read as zero.
- R4: An event in the same cycle as a status read is not lost. The read returns the old value, and the event's bit is 1 after the edge.
- R5: Bit 12 is set when any one or more of the `N_TX_CH` transmit underflow lines is high.
- R6: Address 2 holds the threshold codes. Bits 2:0 are the receive code and bits 6:4 are the transmit code, and all other bits read as zero. Code n raises the done-queue write bit on every 2^n-th write: code 0 means every write and code 7 means every 128th write. The counter restarts from zero each time the bit is raised.
- R7: Address 1 is the interrupt mask. Bits 15:8 can be written and read back, and bits 7:0 read as zero. After each edge, `irq_host` is 1 exactly when some status bit and its mask bit are both 1. It therefore falls after a status read that leaves no masked bit set.
- R8: After each edge, `irq_local` equals `irq_host` ANDed with `cfg_mode` as sampled at that edge.
- R9: Writes to address 0 and address 3 change nothing. Address 3 reads as zero.
- R10: A write to the mask or threshold register takes effect at the next edge. A read of the same address in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 thresholds, 3 unused |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| ev_rx_fq_rd | input | 1 | Receive free-queue read (single or burst) |
| ev_rx_fq_empty | input | 1 | Receive free-queue read found the queue empty |
| ev_rx_dq_wr | input | 1 | Receive done-queue write |
| ev_rx_dq_full | input | 1 | Receive done-queue write found the queue full |
| ev_tx_unf | input | N_TX_CH | Transmit FIFO underflow, one line per channel |
| ev_tx_pq_rd | input | 1 | Transmit pending-queue read |
| ev_tx_dq_wr | input | 1 | Transmit done-queue write |
| ev_tx_dq_full | input | 1 | Transmit done-queue write found the queue full |
| cfg_mode | input | 1 | Local bus is in configuration mode |
| irq_host | output | 1 | Host interrupt request, level |
| irq_local | output | 1 | Local-bus interrupt request, level |

## Verification
The assertions assume that reset is held for at least one clock edge before any check is made. They also assume that every event input is a synchronous pulse sampled on the same clock, so that one high cycle means exactly one event. The stimulus drives all inputs just after the rising edge and holds them for a whole cycle. It applies reset for several edges, then mixes directed sequences with random event patterns, random register accesses and threshold changes made while a coalescing count is in progress.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int REG_W   = 16;
  localparam int STAT_W  = 8;
  localparam int STAT_LO = 8;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_THR  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // index of each event within the 8-bit status vector (register bit = index + 8)
  localparam int IX_RX_FQ_RD    = 0;
  localparam int IX_RX_FQ_EMPTY = 1;
  localparam int IX_RX_DQ_WR    = 2;
  localparam int IX_RX_DQ_FULL  = 3;
  localparam int IX_TX_UNF      = 4;
  localparam int IX_TX_PQ_RD    = 5;
  localparam int IX_TX_DQ_WR    = 6;
  localparam int IX_TX_DQ_FULL  = 7;

  localparam int THR_RX_LSB = 0;
  localparam int THR_TX_LSB = 4;
endpackage

// File: rtl/evt_coalesce.sv
module evt_coalesce #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              wr_ev,
  output logic              fire
);
  localparam int CNT_W = 2 ** CODE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   thresh;
  logic [CNT_W:0]   nxt;

  always_comb begin
    thresh = (CNT_W+1)'(1) << code;
    nxt    = {1'b0, cnt_q} + 1'b1;
    fire   = wr_ev && (nxt >= thresh);
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (fire)  cnt_q <= '0;
    else if (wr_ev) cnt_q <= nxt[CNT_W-1:0];
  end

  // R6: raising the bit needs a write and restarts the count
  p_fire_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
    fire |-> wr_ev);
  p_fire_restarts_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> cnt_q == '0);
  p_count_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_ev |=> $stable(cnt_q));
endmodule

// File: rtl/evt_sticky.sv
module evt_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] status_d,
  output logic [W-1:0] status_q
);
  always_comb status_d = (clr ? '0 : status_q) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  // R2: bits hold without a clearing read
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (status_q & $past(status_q)) == $past(status_q));
  // R2/R4: an event always lands, even with a coincident clear
  p_event_lands_r4: assert property (@(posedge clk) disable iff (rst)
    |set_vec |=> (status_q & $past(set_vec)) == $past(set_vec));
  // R3: a clear with no event leaves nothing set
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && set_vec == '0) |=> status_q == '0);
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_d,
  input  logic [W-1:0] mask_d,
  input  logic         cfg_mode,
  output logic         irq_host,
  output logic         irq_local
);
  logic req;
  always_comb req = |(status_d & mask_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_host  <= 1'b0;
      irq_local <= 1'b0;
    end else begin
      irq_host  <= req;
      irq_local <= req && cfg_mode;
    end
  end

  // R8: local line never asserts without the host line
  p_local_implies_host_r8: assert property (@(posedge clk) disable iff (rst)
    irq_local |-> irq_host);
  // R8: local line silent outside configuration mode
  p_local_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> !irq_local);
endmodule

// File: rtl/dma_evt_stat.sv
module dma_evt_stat
  import dma_evt_pkg::*;
#(
  parameter int N_TX_CH = 8,
  parameter int CODE_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic               ev_rx_fq_rd,
  input  logic               ev_rx_fq_empty,
  input  logic               ev_rx_dq_wr,
  input  logic               ev_rx_dq_full,
  input  logic [N_TX_CH-1:0] ev_tx_unf,
  input  logic               ev_tx_pq_rd,
  input  logic               ev_tx_dq_wr,
  input  logic               ev_tx_dq_full,
  input  logic               cfg_mode,
  output logic               irq_host,
  output logic               irq_local
);
  logic [STAT_W-1:0] status_q, status_d, set_vec;
  logic [STAT_W-1:0] mask_q, mask_d;
  logic [CODE_W-1:0] rx_code_q, tx_code_q;
  logic              rx_fire, tx_fire, stat_clr;
  logic [REG_W-1:0]  rd_val;
  reg_addr_e         a;

  always_comb a = reg_addr_e'(addr);

  evt_coalesce #(.CODE_W(CODE_W)) u_rx_coal (
    .clk(clk), .rst(rst), .code(rx_code_q), .wr_ev(ev_rx_dq_wr), .fire(rx_fire));
  evt_coalesce #(.CODE_W(CODE_W)) u_tx_coal (
    .clk(clk), .rst(rst), .code(tx_code_q), .wr_ev(ev_tx_dq_wr), .fire(tx_fire));

  always_comb begin
    set_vec                 = '0;
    set_vec[IX_RX_FQ_RD]    = ev_rx_fq_rd;
    set_vec[IX_RX_FQ_EMPTY] = ev_rx_fq_empty;
    set_vec[IX_RX_DQ_WR]    = rx_fire;
    set_vec[IX_RX_DQ_FULL]  = ev_rx_dq_full;
    set_vec[IX_TX_UNF]      = |ev_tx_unf;
    set_vec[IX_TX_PQ_RD]    = ev_tx_pq_rd;
    set_vec[IX_TX_DQ_WR]    = tx_fire;
    set_vec[IX_TX_DQ_FULL]  = ev_tx_dq_full;
    stat_clr                = rd_en && (a == A_STAT);
  end

  evt_sticky #(.W(STAT_W)) u_sticky (
    .clk(clk), .rst(rst), .clr(stat_clr), .set_vec(set_vec),
    .status_d(status_d), .status_q(status_q));

  always_comb begin
    mask_d = mask_q;
    if (wr_en && a == A_MASK) mask_d = wdata[STAT_LO +: STAT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      rx_code_q <= '0;
      tx_code_q <= '0;
    end else begin
      mask_q <= mask_d;
      if (wr_en && a == A_THR) begin
        rx_code_q <= wdata[THR_RX_LSB +: CODE_W];
        tx_code_q <= wdata[THR_TX_LSB +: CODE_W];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (a)
      A_STAT: rd_val[STAT_LO +: STAT_W] = status_q;
      A_MASK: rd_val[STAT_LO +: STAT_W] = mask_q;
      A_THR: begin
        rd_val[THR_RX_LSB +: CODE_W] = rx_code_q;
        rd_val[THR_TX_LSB +: CODE_W] = tx_code_q;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  irq_route #(.W(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .status_d(status_d), .mask_d(mask_d),
    .cfg_mode(cfg_mode), .irq_host(irq_host), .irq_local(irq_local));

  // R3: low status byte never reads as one
  p_low_byte_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) && $past(addr) == 2'd0 |-> rdata[STAT_LO-1:0] == '0);
  // R9: address 3 reads zero
  p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) && $past(addr) == 2'd3 |-> rdata == '0);
  // R7: host line follows masked status
  p_host_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_host == |(status_q & mask_q));
  // R3: read data holds between reads
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_dma_evt_stat.sv
`timescale 1ns/1ps
module sim_dma_evt_stat;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic e_fq_rd = 0, e_fq_empty = 0, e_rx_dq = 0, e_rx_full = 0;
  logic [NCH-1:0] e_unf = 0;
  logic e_pq_rd = 0, e_tx_dq = 0, e_tx_full = 0;
  logic cfg = 0;
  logic irq_host, irq_local;

  always #2.5 clk = ~clk;

  dma_evt_stat #(.N_TX_CH(NCH), .CODE_W(3)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .ev_rx_fq_rd(e_fq_rd), .ev_rx_fq_empty(e_fq_empty),
    .ev_rx_dq_wr(e_rx_dq), .ev_rx_dq_full(e_rx_full),
    .ev_tx_unf(e_unf), .ev_tx_pq_rd(e_pq_rd),
    .ev_tx_dq_wr(e_tx_dq), .ev_tx_dq_full(e_tx_full),
    .cfg_mode(cfg), .irq_host(irq_host), .irq_local(irq_local));

  // reference model state
  int m_stat, m_mask, m_rxc, m_txc, m_rxcnt, m_txcnt;
  int x_rdata;
  bit x_host, x_local;
  int n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic tick();
    int rv, ns;
    if (rst) begin
      m_stat = 0; m_mask = 0; m_rxc = 0; m_txc = 0; m_rxcnt = 0; m_txcnt = 0;
      x_rdata = 0; x_host = 0; x_local = 0;
    end else begin
      case (addr)
        2'd0: rv = m_stat << 8;
        2'd1: rv = m_mask << 8;
        2'd2: rv = m_rxc | (m_txc << 4);
        default: rv = 0;
      endcase
      if (rd_en) x_rdata = rv;
      ns = (rd_en && addr == 2'd0) ? 0 : m_stat;
      if (e_fq_rd)    ns |= 1;
      if (e_fq_empty) ns |= 2;
      if (e_rx_dq) begin
        m_rxcnt++;
        if (m_rxcnt >= (1 << m_rxc)) begin ns |= 4; m_rxcnt = 0; end
      end
      if (e_rx_full)  ns |= 8;
      if (e_unf != 0) ns |= 16;
      if (e_pq_rd)    ns |= 32;
      if (e_tx_dq) begin
        m_txcnt++;
        if (m_txcnt >= (1 << m_txc)) begin ns |= 64; m_txcnt = 0; end
      end
      if (e_tx_full)  ns |= 128;
      if (wr_en && addr == 2'd1) m_mask = int'(wdata[15:8]);
      if (wr_en && addr == 2'd2) begin
        m_rxc = int'(wdata[2:0]); m_txc = int'(wdata[6:4]);
      end
      m_stat = ns;
      x_host = (m_stat & m_mask) != 0;
      x_local = x_host && cfg;
    end
    @(posedge clk);
    #1;
    n_vec++;
    if (rdata !== 16'(x_rdata) || irq_host !== x_host || irq_local !== x_local) begin
      n_bad++;
      $display("FAIL %s: rdata=%h host=%b local=%b expected rdata=%h host=%b local=%b",
               cur_req, rdata, irq_host, irq_local, 16'(x_rdata), x_host, x_local);
    end
  endtask

  task automatic clear_ev();
    e_fq_rd = 0; e_fq_empty = 0; e_rx_dq = 0; e_rx_full = 0;
    e_unf = '0; e_pq_rd = 0; e_tx_dq = 0; e_tx_full = 0;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1; addr = a; tick(); rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    cur_req = "R1"; rst = 1; idle(3);
    rst = 0; idle(1);
    rd(2'd0); rd(2'd1); rd(2'd2);

    // R2: each event to its own bit, sticky across idle cycles
    cur_req = "R2";
    wr(2'd1, 16'hFF00);
    e_fq_rd = 1; tick(); clear_ev(); idle(2); rd(2'd0); idle(1);
    e_fq_empty = 1; tick(); clear_ev();
    e_rx_full = 1; tick(); clear_ev();
    e_pq_rd = 1; tick(); clear_ev();
    e_tx_full = 1; tick(); clear_ev();
    e_rx_dq = 1; tick(); clear_ev();
    e_tx_dq = 1; tick(); clear_ev();
    idle(2); rd(2'd0); rd(2'd0);

    // R5: underflow on single channels and several at once
    cur_req = "R5";
    for (int c = 0; c < NCH; c++) begin
      e_unf = '0; e_unf[c] = 1'b1; tick(); clear_ev(); rd(2'd0);
    end
    e_unf = 8'hA5; tick(); clear_ev(); rd(2'd0); rd(2'd0);

    // R4: event coincident with status read
    cur_req = "R4";
    e_pq_rd = 1; tick(); clear_ev();
    rd_en = 1; addr = 2'd0; e_fq_empty = 1; tick(); clear_ev();
    rd(2'd0); rd(2'd0);

    // R6: coalescing codes, including a mid-count change
    cur_req = "R6";
    wr(2'd2, 16'hFF31); rd(2'd2);
    for (int i = 0; i < 20; i++) begin
      e_rx_dq = 1; e_tx_dq = (i % 3) != 0; tick(); clear_ev();
      if (i % 5 == 4) rd(2'd0);
    end
    wr(2'd2, 16'h0077); rd(2'd2);
    for (int i = 0; i < 260; i++) begin
      e_rx_dq = 1; e_tx_dq = 1; tick(); clear_ev();
      if (i % 64 == 63) rd(2'd0);
    end
    wr(2'd2, 16'h0002);
    for (int i = 0; i < 12; i++) begin e_rx_dq = 1; tick(); clear_ev(); end
    rd(2'd0);

    // R7: mask selects interrupt sources; low byte ignored
    cur_req = "R7";
    wr(2'd1, 16'h24FF); rd(2'd1);
    e_fq_rd = 1; tick(); clear_ev(); idle(1);
    e_unf = 8'h01; tick(); clear_ev(); idle(1);
    rd(2'd0); idle(1);

    // R8: local line gated by configuration mode
    cur_req = "R8";
    wr(2'd1, 16'hFF00);
    e_tx_full = 1; tick(); clear_ev();
    idle(1); cfg = 1; idle(2); cfg = 0; idle(1); cfg = 1; idle(1);
    rd(2'd0); idle(1); cfg = 0;

    // R9: writes to status and unused address do nothing
    cur_req = "R9";
    e_rx_full = 1; tick(); clear_ev();
    wr(2'd0, 16'hFFFF); wr(2'd3, 16'hFFFF);
    rd(2'd3); rd(2'd0); rd(2'd1); rd(2'd2);

    // R10: read and write of the same register in one cycle
    cur_req = "R10";
    rd_en = 1; wr_en = 1; addr = 2'd1; wdata = 16'h1200; tick(); clear_ev();
    rd(2'd1);
    rd_en = 1; wr_en = 1; addr = 2'd2; wdata = 16'h0053; tick(); clear_ev();
    rd(2'd2);

    // R3: random mix against the model
    cur_req = "R3";
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      e_fq_rd = ($urandom_range(0, 7) == 0);
      e_fq_empty = ($urandom_range(0, 15) == 0);
      e_rx_dq = ($urandom_range(0, 1) == 0);
      e_rx_full = ($urandom_range(0, 15) == 0);
      e_unf = ($urandom_range(0, 9) == 0) ? NCH'($urandom) : '0;
      e_pq_rd = ($urandom_range(0, 7) == 0);
      e_tx_dq = ($urandom_range(0, 1) == 0);
      e_tx_full = ($urandom_range(0, 15) == 0);
      cfg = ($urandom_range(0, 3) != 0);
      addr = 2'($urandom);
      rd_en = (r < 30);
      wr_en = (r >= 90);
      wdata = 16'($urandom);
      if (wr_en && addr == 2'd2) wdata[6:0] = 7'($urandom_range(0, 3)) | 7'h10;
      tick();
      clear_ev();
    end

    cur_req = "R1";
    rst = 1; idle(2); rst = 0; rd(2'd1); rd(2'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule